// File: doc/BRIEF.md
# Display Control Register Decoder

This block takes 32-bit words written to a display control port and turns them into machine state. The top byte of each word is an opcode. Depending on it, the block changes fields of a 32-bit status word, latches the display start position and the horizontal and vertical display ranges, or prepares a read-back word that answers an information query. The read-back word is built from the eight environment register values that the neighbouring command framer presents on a flat input bus.

Two opcodes act on neighbouring blocks. Each drives a single-cycle request pulse: one asks for a full reset, the other asks for a flush of a partly received command. The current horizontal resolution and dot-clock divider are decoded from the status word and kept on the outputs at all times.

A copy of the last word written for each low opcode is kept. A repeated identical write is dropped, and the `write_taken` pulse shows whether each write took effect.

Top module: `dispctl_decoder`

## Requirements
- R1: After `rst_n` is released, and on the edge after a write with opcode (bits 31:24) 0x00, `status_word` is 0x14802000 and `readback` is 0. After opcode 0x00, `reset_req` and `flush_req` are both high for exactly one cycle. The stored copy for opcode 0x03 becomes the literal value 1, so a later write of 0x03000001 is not treated as a repeat.
- R2: Opcode 0x01 raises only `flush_req` for one cycle. `status_word` does not change.
- R3: Opcode 0x03 sets status bit 23 (blanking) when data bit 0 is 1, and clears it when data bit 0 is 0.
- R4: Opcode 0x04 replaces status bits 30:29 with data bits 1:0.
- R5: Opcode 0x05 loads `disp_x` from data bits 9:0 and `disp_y` from data bits 18:10.
- R6: Opcode 0x06 loads `hrange_x1` from bits 11:0 and `hrange_x2` from bits 23:12. Opcode 0x07 loads `vrange_y1` from bits 9:0 and `vrange_y2` from bits 19:10.
- R7: Opcode 0x08 clears status bits 22:16, then puts data bits 5:0 into status bits 22:17 and data bit 6 into status bit 16.
- R8: Status bits 18:16 (value k = 0..7) give `hres` = {256,368,320,368,512,368,640,368}[k] and `dot_div` = {10,7,8,7,5,7,4,7}[k].
- R9: An opcode from 0x10 to 0x1F sets `readback` according to data bits 3:0:
  - 2, 3 or 4: bits 19:0 of environment register n, zero-extended.
  - 5: bits 21:0 of environment register 5.
  - 7: the constant 2.
  - Any other value: `readback` is unchanged.
- R10: For opcodes 0x02 to 0x0F other than 0x05, a write whose whole word equals the stored copy for that opcode has no effect and `write_taken` stays low. Opcodes 0x00, 0x01 and 0x05 are never dropped.
- R11: Each write changes the outputs on the following clock edge. `write_taken` is high for one cycle after every write that was not dropped. With no write, `status_word` and `readback` hold their values.
- R12: A write with an opcode of 0x20 or above changes neither `status_word` nor `readback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word; bits 31:24 are the opcode |
| env_regs | input | 256 | Eight environment register values, register n at bits 32n+31:32n |
| status_word | output | 32 | Status register |
| disp_x | output | 10 | Display start X |
| disp_y | output | 9 | Display start Y |
| hrange_x1 | output | 12 | Horizontal range start |
| hrange_x2 | output | 12 | Horizontal range end |
| vrange_y1 | output | 10 | Vertical range start |
| vrange_y2 | output | 10 | Vertical range end |
| hres | output | 10 | Horizontal resolution decoded from the status word |
| dot_div | output | 4 | Dot-clock divider decoded from the status word |
| readback | output | 32 | Information query answer |
| reset_req | output | 1 | One-cycle full reset request |
| flush_req | output | 1 | One-cycle command flush request |
| write_taken | output | 1 | One-cycle pulse for a write that was not dropped |

## Verification
The bench builds the block with its default parameters: eight 32-bit environment registers and a stored copy for each of the sixteen low opcodes. With these values every information query index and every droppable opcode can be reached. The 3-bit resolution selector covers all eight table entries, which lets the vector walk hit several resolution settings. The full-width environment registers show the 20-bit and 22-bit masks clearly.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OP_FULL_RESET = 8'h00;
  localparam logic [7:0] OP_FLUSH      = 8'h01;
  localparam logic [7:0] OP_BLANK      = 8'h03;
  localparam logic [7:0] OP_DMA_DIR    = 8'h04;
  localparam logic [7:0] OP_START      = 8'h05;
  localparam logic [7:0] OP_HRANGE     = 8'h06;
  localparam logic [7:0] OP_VRANGE     = 8'h07;
  localparam logic [7:0] OP_MODE       = 8'h08;

  localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

  localparam int unsigned BLANK_BIT = 23;
  localparam int unsigned DMA_LO    = 29;
  localparam int unsigned MODE_LO   = 16;

  // Horizontal resolution for the 3-bit selector held in status bits 18:16.
  function automatic logic [9:0] hres_of(input logic [2:0] sel);
    logic [9:0] r;
    if (sel[0]) r = 10'd368;
    else begin
      case (sel[2:1])
        2'd0:    r = 10'd256;
        2'd1:    r = 10'd320;
        2'd2:    r = 10'd512;
        default: r = 10'd640;
      endcase
    end
    return r;
  endfunction

  // Dot-clock divider for the same selector.
  function automatic logic [3:0] div_of(input logic [2:0] sel);
    logic [3:0] r;
    if (sel[0]) r = 4'd7;
    else begin
      case (sel[2:1])
        2'd0:    r = 4'd10;
        2'd1:    r = 4'd8;
        2'd2:    r = 4'd5;
        default: r = 4'd4;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/dispctl_shadow.sv
module dispctl_shadow #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dup_hit
);
  localparam int unsigned IDX_W = $clog2(SLOTS);

  logic [WORD_W-1:0] copy_q [SLOTS];
  logic [7:0]        op;
  logic              in_range;
  logic              droppable;
  logic [IDX_W-1:0]  idx;

  assign op        = wr_data[WORD_W-1 -: 8];
  assign in_range  = (op < 8'(SLOTS));
  assign idx       = op[IDX_W-1:0];
  assign droppable = in_range && (op >= 8'h02) && (op != dispctl_pkg::OP_START);
  assign dup_hit   = wr_en && droppable && (copy_q[idx] == wr_data);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < 2) begin : g_unused
      assign copy_q[g] = '0;
    end else begin : g_kept
      localparam logic [WORD_W-1:0] INIT = (g == 3) ? WORD_W'(1) : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          copy_q[g] <= INIT;
        end else if (wr_en && op == dispctl_pkg::OP_FULL_RESET) begin
          copy_q[g] <= INIT;
        end else if (wr_en && in_range && idx == IDX_W'(g)) begin
          copy_q[g] <= wr_data;
        end
      end
    end
  end

endmodule

// File: rtl/dispctl_status.sv
module dispctl_status #(
  parameter int unsigned ENV_N  = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [ENV_N*WORD_W-1:0] env_regs,
  output logic [WORD_W-1:0]       status_word,
  output logic [WORD_W-1:0]       readback,
  output logic                    reset_req,
  output logic                    flush_req
);
  import dispctl_pkg::*;
  localparam int unsigned ENV_IDX_W = $clog2(ENV_N);

  logic [7:0]           op;
  logic [3:0]           sub;
  logic [WORD_W-1:0]    env_pick;
  logic [ENV_IDX_W-1:0] env_idx;

  assign op       = wr_data[WORD_W-1 -: 8];
  assign sub      = wr_data[3:0];
  assign env_idx  = wr_data[ENV_IDX_W-1:0];
  assign env_pick = env_regs[env_idx*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_word <= STATUS_INIT;
      readback    <= '0;
      reset_req   <= 1'b0;
      flush_req   <= 1'b0;
    end else begin
      reset_req <= take && (op == OP_FULL_RESET);
      flush_req <= take && (op == OP_FULL_RESET || op == OP_FLUSH);
      if (take) begin
        case (op)
          OP_FULL_RESET: begin
            status_word <= STATUS_INIT;
            readback    <= '0;
          end
          OP_BLANK:   status_word[BLANK_BIT] <= wr_data[0];
          OP_DMA_DIR: status_word[DMA_LO +: 2] <= wr_data[1:0];
          OP_MODE:    status_word[MODE_LO +: 7] <= {wr_data[5:0], wr_data[6]};
          default: begin
            if (op[7:4] == 4'h1) begin
              case (sub)
                4'd2, 4'd3, 4'd4: readback <= {12'd0, env_pick[19:0]};
                4'd5:             readback <= {10'd0, env_pick[21:0]};
                4'd7:             readback <= WORD_W'(2);
                default:          readback <= readback;
              endcase
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dispctl_geom.sv
module dispctl_geom #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] wr_data,
  output logic [9:0]        disp_x,
  output logic [8:0]        disp_y,
  output logic [11:0]       hrange_x1,
  output logic [11:0]       hrange_x2,
  output logic [9:0]        vrange_y1,
  output logic [9:0]        vrange_y2
);
  import dispctl_pkg::*;

  logic [7:0] op;
  assign op = wr_data[WORD_W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_x    <= '0;
      disp_y    <= '0;
      hrange_x1 <= '0;
      hrange_x2 <= '0;
      vrange_y1 <= '0;
      vrange_y2 <= '0;
    end else if (take) begin
      case (op)
        OP_START: begin
          disp_x <= wr_data[9:0];
          disp_y <= wr_data[18:10];
        end
        OP_HRANGE: begin
          hrange_x1 <= wr_data[11:0];
          hrange_x2 <= wr_data[23:12];
        end
        OP_VRANGE: begin
          vrange_y1 <= wr_data[9:0];
          vrange_y2 <= wr_data[19:10];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder #(
  parameter int unsigned ENV_N  = 8,
  parameter int unsigned SLOTS  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [31:0]  wr_data,
  input  logic [255:0] env_regs,
  output logic [31:0]  status_word,
  output logic [9:0]   disp_x,
  output logic [8:0]   disp_y,
  output logic [11:0]  hrange_x1,
  output logic [11:0]  hrange_x2,
  output logic [9:0]   vrange_y1,
  output logic [9:0]   vrange_y2,
  output logic [9:0]   hres,
  output logic [3:0]   dot_div,
  output logic [31:0]  readback,
  output logic         reset_req,
  output logic         flush_req,
  output logic         write_taken
);
  import dispctl_pkg::*;

  logic dup_hit;
  logic take;

  assign take = wr_en && !dup_hit;

  dispctl_shadow #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .dup_hit(dup_hit)
  );

  dispctl_status #(.ENV_N(ENV_N), .WORD_W(WORD_W)) u_status (
    .clk(clk), .rst_n(rst_n), .take(take), .wr_data(wr_data), .env_regs(env_regs),
    .status_word(status_word), .readback(readback),
    .reset_req(reset_req), .flush_req(flush_req)
  );

  dispctl_geom #(.WORD_W(WORD_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .take(take), .wr_data(wr_data),
    .disp_x(disp_x), .disp_y(disp_y),
    .hrange_x1(hrange_x1), .hrange_x2(hrange_x2),
    .vrange_y1(vrange_y1), .vrange_y2(vrange_y2)
  );

  assign hres    = hres_of(status_word[18:16]);
  assign dot_div = div_of(status_word[18:16]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) write_taken <= 1'b0;
    else        write_taken <= take;
  end

endmodule

// File: rtl/dispctl_checker.sv
module dispctl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] status_word,
  input logic [31:0] readback,
  input logic [9:0]  hres,
  input logic [3:0]  dot_div,
  input logic        reset_req,
  input logic        flush_req,
  input logic        write_taken,
  input logic        dup_hit
);

  assert_reset_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (status_word == 32'h1480_2000 && readback == 32'd0 && flush_req));

  assert_flush_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(wr_en && wr_data[31:25] == 7'd0));

  assert_mode_scatter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dup_hit && wr_data[31:24] == 8'h08) |=> (status_word[22:17] == $past(wr_data[5:0])));

  assert_table_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hres == 10'd640) == (dot_div == 4'd4));

  assert_dup_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dup_hit |=> ($stable(status_word) && !write_taken));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(status_word) && $stable(readback) && !write_taken));

endmodule

bind dispctl_decoder dispctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .status_word(status_word), .readback(readback), .hres(hres), .dot_div(dot_div),
  .reset_req(reset_req), .flush_req(flush_req), .write_taken(write_taken),
  .dup_hit(dup_hit)
);

// File: tb/dispctl_decoder_test.sv
module dispctl_decoder_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [255:0] env_regs;
  logic [31:0]  status_word, readback;
  logic [9:0]   disp_x, vrange_y1, vrange_y2, hres;
  logic [8:0]   disp_y;
  logic [11:0]  hrange_x1, hrange_x2;
  logic [3:0]   dot_div;
  logic         reset_req, flush_req, write_taken;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dispctl_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .env_regs(env_regs),
    .status_word(status_word), .disp_x(disp_x), .disp_y(disp_y),
    .hrange_x1(hrange_x1), .hrange_x2(hrange_x2),
    .vrange_y1(vrange_y1), .vrange_y2(vrange_y2),
    .hres(hres), .dot_div(dot_div), .readback(readback),
    .reset_req(reset_req), .flush_req(flush_req), .write_taken(write_taken)
  );

  function automatic logic [31:0] env_val(input int i);
    return {8'(8'hE0 + i), 24'h9A5C30 | 24'(i)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one word for one cycle; return at the falling edge after the edge that took it.
  task automatic put(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // data, status, hres, div, taken
  localparam int NV = 11;
  localparam logic [78:0] VEC [NV] = '{
    {32'h0300_0000, 32'h1400_2000, 10'd256, 4'd10, 1'b1},
    {32'h0300_0000, 32'h1400_2000, 10'd256, 4'd10, 1'b0},
    {32'h0400_0003, 32'h7400_2000, 10'd256, 4'd10, 1'b1},
    {32'h0400_0001, 32'h3400_2000, 10'd256, 4'd10, 1'b1},
    {32'h0800_0045, 32'h340B_2000, 10'd368, 4'd7,  1'b1},
    {32'h0800_0002, 32'h3404_2000, 10'd512, 4'd5,  1'b1},
    {32'h0800_0002, 32'h3404_2000, 10'd512, 4'd5,  1'b0},
    {32'h2000_1234, 32'h3404_2000, 10'd512, 4'd5,  1'b1},
    {32'h0100_0000, 32'h3404_2000, 10'd512, 4'd5,  1'b1},
    {32'h0800_0003, 32'h3406_2000, 10'd640, 4'd4,  1'b1},
    {32'h0300_0001, 32'h3486_2000, 10'd640, 4'd4,  1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R11: watchdog expired, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) env_regs[i*32 +: 32] = env_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R8 table entry 0
    check("R1 status", status_word, 32'h1480_2000);
    check("R1 readback", readback, 32'd0);
    check("R1 no pulses", {29'd0, reset_req, flush_req, write_taken}, 32'd0);
    check("R8 hres", 32'(hres), 32'd256);
    check("R8 div", 32'(dot_div), 32'd10);

    // Vector walk: R3 R4 R7 R8 R10 R12 R2
    for (int v = 0; v < NV; v++) begin
      put(VEC[v][78:47]);
      check("R3/R4/R7/R12 status", status_word, VEC[v][46:15]);
      check("R8 hres", 32'(hres), 32'(VEC[v][14:5]));
      check("R8 div", 32'(dot_div), 32'(VEC[v][4:1]));
      check("R10/R11 write_taken", 32'(write_taken), 32'(VEC[v][0]));
      if (VEC[v][78:71] == 8'h01) begin
        check("R2 flush pulse", {30'd0, reset_req, flush_req}, 32'd1);
        @(negedge clk);
        check("R2 flush single cycle", 32'(flush_req), 32'd0);
      end
    end
    check("R12 readback untouched", readback, 32'd0);

    // R5 / R6 geometry
    put(32'h0503_FC2A);
    check("R5 disp_x", 32'(disp_x), 32'h02A);
    check("R5 disp_y", 32'(disp_y), 32'h0FF);
    put(32'h0503_FC2A);
    check("R10 start never dropped", 32'(write_taken), 32'd1);
    put(32'h06AB_C123);
    check("R6 x1", 32'(hrange_x1), 32'h123);
    check("R6 x2", 32'(hrange_x2), 32'hABC);
    put(32'h0708_7C05);
    check("R6 y1", 32'(vrange_y1), 32'h005);
    check("R6 y2", 32'(vrange_y2), 32'h21F);

    // R9 information queries
    put(32'h1000_0002);
    check("R9 idx2", readback, env_val(2) & 32'h000F_FFFF);
    put(32'h1000_0003);
    check("R9 idx3", readback, env_val(3) & 32'h000F_FFFF);
    put(32'h1F00_0004);
    check("R9 idx4", readback, env_val(4) & 32'h000F_FFFF);
    put(32'h1000_0005);
    check("R9 idx5", readback, env_val(5) & 32'h003F_FFFF);
    put(32'h1000_0009);
    check("R9 other unchanged", readback, env_val(5) & 32'h003F_FFFF);
    put(32'h1000_0007);
    check("R9 const", readback, 32'd2);
    @(negedge clk);
    check("R11 idle hold", readback, 32'd2);

    // R1 full reset by opcode
    put(32'h0000_0000);
    check("R1 status", status_word, 32'h1480_2000);
    check("R1 readback", readback, 32'd0);
    check("R1 pulses", {30'd0, reset_req, flush_req}, 32'd3);
    @(negedge clk);
    check("R1 pulses end", {30'd0, reset_req, flush_req}, 32'd0);
    put(32'h0300_0001);
    check("R1 blank copy is literal 1", 32'(write_taken), 32'd1);
    put(32'h0300_0001);
    check("R10 repeat dropped", 32'(write_taken), 32'd0);
    put(32'h0800_0002);
    check("R10 copy cleared by reset", 32'(write_taken), 32'd1);
    check("R7 after reset", status_word, 32'h1484_2000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule